// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Interrupt Detection

This block controls one general-purpose I/O pin and is instantiated once per pin. Software reaches it through a small register bus: address, write data, write strobe, and read data that is combinational from the address. The block drives the pad's output value and output enable. It also drives a function-select code, a drive-strength code and a pull code for the pad ring. The pad level is brought in through a configurable synchroniser.

Interrupt detection runs on the synchronised pad level. A 2-bit mode field selects one of four detection modes:

- level, where a polarity bit chooses whether a low or a high level is active;
- rising edge;
- falling edge;
- either edge.

The detected event is held in a status bit. Software clears that bit by writing to it, and a parameter decides whether the clearing value is 1 or 0. An enable bit gates the status onto the interrupt output.

A raw-detect enable bit lets events reach the status bit at all. While it is off, the edge detector's previous-sample register stops updating. Turning the bit back on can therefore report an edge that is not real. For this reason the bit is set at reset and is meant to stay set. A 3-bit routing field names the processor that should take the interrupt.

Top module: `gpio_pin`

## Requirements
- R1: After reset every pad-ring output, `irq_o`, `target_o` and the status bit are 0. The interrupt config register (address 2) reads 0x14: enable at bit 0 = 0, polarity at bit 1 = 0, mode at bits 3:2 = 1 (rising), raw-detect enable at bit 4 = 1.
- R2: The control register (address 2'd0) holds four fields, and each drives its output directly. Pull is at bits 1:0 (0 none, 1 pull-down, 2 keeper, 3 pull-up). Function select is at bits 4:2. Drive code d is at bits 7:5 and means (d+1)*2 mA. Output enable is at bit 8.
- R3: In the I/O register (address 1), bit 1 is the output value driven on `pad_out_o`. Bit 0 is read-only and returns the pad level two clock edges after it is applied. Writes to bit 0 are ignored.
- R4: Mode 0 is level mode. With polarity 1 the status is set while the synchronised input is high; with polarity 0 it is set while the input is low. The status follows the level and clears one edge after the level stops matching.
- R5: In level mode, an acknowledge clears the status for one cycle. The status sets again on the next edge if the level is still active.
- R6: Modes 1, 2 and 3 latch the status on a rising, falling or either edge respectively, and the polarity bit has no effect in these modes. The status then stays set until it is acknowledged.
- R7: A write to the status register (address 3) acknowledges only when wdata bit 0 equals the `ACK_SET` parameter (default 1). A write of the other value leaves the status unchanged.
- R8: In edge modes, if an edge is detected in the same cycle as an acknowledge, the status stays set.
- R9: `irq_o` is the status gated by the enable bit. Clearing the enable bit masks `irq_o` but leaves the status bit readable and unchanged.
- R10: While raw-detect enable is 0, no event sets the status and the previous-sample register holds its value. If the bit is re-enabled while the pad level differs from the held sample, a rising-mode edge is reported.
- R11: The routing register (address 4) bits 2:0 drive `target_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| pad_i | input | 1 | Asynchronous pad level |
| pad_out_o | output | 1 | Pad output value |
| pad_oe_o | output | 1 | Pad output enable |
| func_o | output | FUNC_W | Function-select code |
| drive_o | output | DRV_W | Drive-strength code |
| pull_o | output | 2 | Pull code |
| target_o | output | TGT_W | Interrupt routing target |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The assertions assume that each write strobe lasts one cycle with a stable address. They also assume that the status register only changes through detection or an acknowledge, never by a direct write of a set value. The bench drives the bus and the pad only on falling clock edges, with writes one cycle long, so every change is sampled cleanly on the following rising edge. For the set-versus-acknowledge race, the pad and the acknowledge are placed so that the detected edge and the acknowledge fall on the same rising edge.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_IO   = 1;
  localparam int unsigned REG_CFG  = 2;
  localparam int unsigned REG_STAT = 3;
  localparam int unsigned REG_TGT  = 4;

  localparam int unsigned PULL_W        = 2;
  localparam int unsigned CFG_EN_BIT    = 0;
  localparam int unsigned CFG_POL_BIT   = 1;
  localparam int unsigned CFG_MODE_LSB  = 2;
  localparam int unsigned CFG_RAW_BIT   = 4;
  localparam int unsigned IO_IN_BIT     = 0;
  localparam int unsigned IO_OUT_BIT    = 1;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  input  logic track_i,
  output logic sync_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b0;
      else if (i == 0) chain_q[i] <= pad_i;
      else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
    end
  end

  // previous sample freezes while detection is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else if (track_i) prev_q <= chain_q[STAGES-1];
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_pin_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cur_i,
  input  logic      prev_i,
  input  det_mode_e mode_i,
  input  logic      pol_i,
  input  logic      raw_en_i,
  input  logic      ack_i,
  output logic      status_o
);
  logic hit, status_d, status_q;

  always_comb begin
    unique case (mode_i)
      DET_LEVEL: hit = (cur_i == pol_i);
      DET_RISE:  hit = cur_i & ~prev_i;
      DET_FALL:  hit = ~cur_i & prev_i;
      default:   hit = cur_i ^ prev_i;
    endcase
    hit = hit & raw_en_i;
  end

  // level: follows the qualifier; edge: sticky, set beats ack
  assign status_d = (mode_i == DET_LEVEL) ? (hit & ~ack_i)
                                          : (hit | (status_q & ~ack_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_pin_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned FUNC_W  = 3,
  parameter int unsigned DRV_W   = 3,
  parameter int unsigned TGT_W   = 3,
  parameter bit          ACK_SET = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              pad_sync_i,
  input  logic              status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PULL_W-1:0] pull_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [DRV_W-1:0]  drive_o,
  output logic              oe_o,
  output logic              out_o,
  output logic              en_o,
  output logic              pol_o,
  output det_mode_e         mode_o,
  output logic              raw_en_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              ack_o
);
  localparam int unsigned PULL_LSB = 0;
  localparam int unsigned FUNC_LSB = PULL_LSB + PULL_W;
  localparam int unsigned DRV_LSB  = FUNC_LSB + FUNC_W;
  localparam int unsigned OE_BIT   = DRV_LSB + DRV_W;

  logic wr_ctrl, wr_io, wr_cfg, wr_tgt;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_io   = we_i && (addr_i == ADDR_W'(REG_IO));
  assign wr_cfg  = we_i && (addr_i == ADDR_W'(REG_CFG));
  assign wr_tgt  = we_i && (addr_i == ADDR_W'(REG_TGT));
  assign ack_o   = we_i && (addr_i == ADDR_W'(REG_STAT)) && (wdata_i[0] == ACK_SET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_o   <= '0;
      func_o   <= '0;
      drive_o  <= '0;
      oe_o     <= 1'b0;
      out_o    <= 1'b0;
      en_o     <= 1'b0;
      pol_o    <= 1'b0;
      mode_o   <= DET_RISE;
      raw_en_o <= 1'b1;
      target_o <= '0;
    end else begin
      if (wr_ctrl) begin
        pull_o  <= wdata_i[PULL_LSB +: PULL_W];
        func_o  <= wdata_i[FUNC_LSB +: FUNC_W];
        drive_o <= wdata_i[DRV_LSB +: DRV_W];
        oe_o    <= wdata_i[OE_BIT];
      end
      if (wr_io) out_o <= wdata_i[IO_OUT_BIT];
      if (wr_cfg) begin
        en_o     <= wdata_i[CFG_EN_BIT];
        pol_o    <= wdata_i[CFG_POL_BIT];
        mode_o   <= det_mode_e'(wdata_i[CFG_MODE_LSB +: 2]);
        raw_en_o <= wdata_i[CFG_RAW_BIT];
      end
      if (wr_tgt) target_o <= wdata_i[TGT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(REG_CTRL): begin
        rdata_o[PULL_LSB +: PULL_W] = pull_o;
        rdata_o[FUNC_LSB +: FUNC_W] = func_o;
        rdata_o[DRV_LSB +: DRV_W]   = drive_o;
        rdata_o[OE_BIT]             = oe_o;
      end
      ADDR_W'(REG_IO): begin
        rdata_o[IO_IN_BIT]  = pad_sync_i;
        rdata_o[IO_OUT_BIT] = out_o;
      end
      ADDR_W'(REG_CFG): begin
        rdata_o[CFG_EN_BIT]         = en_o;
        rdata_o[CFG_POL_BIT]        = pol_o;
        rdata_o[CFG_MODE_LSB +: 2]  = mode_o;
        rdata_o[CFG_RAW_BIT]        = raw_en_o;
      end
      ADDR_W'(REG_STAT): rdata_o[0] = status_i;
      ADDR_W'(REG_TGT):  rdata_o[TGT_W-1:0] = target_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_pin_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned FUNC_W      = 3,
  parameter int unsigned DRV_W       = 3,
  parameter int unsigned TGT_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ACK_SET     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pad_i,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [DRV_W-1:0]  drive_o,
  output logic [1:0]        pull_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              irq_o
);
  logic      sync_w, prev_w, en_w, pol_w, raw_w, ack_w, status_w;
  det_mode_e mode_w;

  gpio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pad_i   (pad_i),
    .track_i (raw_w),
    .sync_o  (sync_w),
    .prev_o  (prev_w)
  );

  gpio_pin_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FUNC_W(FUNC_W),
    .DRV_W(DRV_W), .TGT_W(TGT_W), .ACK_SET(ACK_SET)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .we_i       (we_i),
    .pad_sync_i (sync_w),
    .status_i   (status_w),
    .rdata_o    (rdata_o),
    .pull_o     (pull_o),
    .func_o     (func_o),
    .drive_o    (drive_o),
    .oe_o       (pad_oe_o),
    .out_o      (pad_out_o),
    .en_o       (en_w),
    .pol_o      (pol_w),
    .mode_o     (mode_w),
    .raw_en_o   (raw_w),
    .target_o   (target_o),
    .ack_o      (ack_w)
  );

  gpio_pin_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_i    (sync_w),
    .prev_i   (prev_w),
    .mode_i   (mode_w),
    .pol_i    (pol_w),
    .raw_en_i (raw_w),
    .ack_i    (ack_w),
    .status_o (status_w)
  );

  assign irq_o = status_w & en_w;
endmodule

// File: rtl/gpio_pin_chk.sv
module gpio_pin_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned FUNC_W = 3,
  parameter int unsigned DRV_W  = 3,
  parameter int unsigned TGT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              pad_out_o,
  input logic              pad_oe_o,
  input logic [FUNC_W-1:0] func_o,
  input logic [DRV_W-1:0]  drive_o,
  input logic [1:0]        pull_o,
  input logic [TGT_W-1:0]  target_o,
  input logic [1:0]        mode,
  input logic              raw_en,
  input logic              ack,
  input logic              status
);
  localparam int unsigned FUNC_LSB = 2;
  localparam int unsigned DRV_LSB  = FUNC_LSB + FUNC_W;
  localparam int unsigned OE_BIT   = DRV_LSB + DRV_W;

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0)) |=>
      (pull_o == $past(wdata_i[1:0]) && func_o == $past(wdata_i[FUNC_LSB +: FUNC_W]) &&
       drive_o == $past(wdata_i[DRV_LSB +: DRV_W]) && pad_oe_o == $past(wdata_i[OE_BIT])));

  p_out_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(1)) |=> pad_out_o == $past(wdata_i[1]));

  p_level_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd0 && ack) |=> !status);

  p_edge_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != 2'd0 && status && !ack) |=> status);

  p_raw_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_en && !status) |=> !status);

  p_target_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(4)) |=> target_o == $past(wdata_i[TGT_W-1:0]));
endmodule

bind gpio_pin gpio_pin_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FUNC_W(FUNC_W), .DRV_W(DRV_W), .TGT_W(TGT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .func_o    (func_o),
  .drive_o   (drive_o),
  .pull_o    (pull_o),
  .target_o  (target_o),
  .mode      (mode_w),
  .raw_en    (raw_w),
  .ack       (ack_w),
  .status    (status_w)
);

// File: tb/gpio_pin_test.sv
module gpio_pin_test;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam bit ACK = 1'b1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          pad = 1'b0;
  logic [DW-1:0] rdata;
  logic          pad_out, pad_oe, irq;
  logic [2:0]    func, drive, target;
  logic [1:0]    pull;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_pin #(.DATA_W(DW), .ADDR_W(AW), .ACK_SET(ACK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pad_i(pad), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .func_o(func), .drive_o(drive), .pull_o(pull), .target_o(target), .irq_o(irq)
  );

  // behavioural reference
  int m_s1, m_s2, m_prev, m_st;
  int m_pull, m_func, m_drv, m_oe, m_out, m_en, m_pol, m_mode, m_raw, m_tgt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_st = 0;
      m_pull = 0; m_func = 0; m_drv = 0; m_oe = 0; m_out = 0;
      m_en = 0; m_pol = 0; m_mode = 1; m_raw = 1; m_tgt = 0;
    end else begin
      int hit, ackv, nst, nprev;
      case (m_mode)
        0: hit = (m_s2 == m_pol);
        1: hit = (m_s2 == 1 && m_prev == 0);
        2: hit = (m_s2 == 0 && m_prev == 1);
        default: hit = (m_s2 != m_prev);
      endcase
      if (m_raw == 0) hit = 0;
      ackv = (we && addr == 3 && wdata[0] == ACK) ? 1 : 0;
      if (m_mode == 0) nst = (hit && !ackv) ? 1 : 0;
      else             nst = (hit || (m_st && !ackv)) ? 1 : 0;
      nprev = m_raw ? m_s2 : m_prev;
      m_prev = nprev; m_s2 = m_s1; m_s1 = pad; m_st = nst;
      if (we) begin
        case (addr)
          0: begin m_pull = wdata & 3; m_func = (wdata >> 2) & 7;
                   m_drv = (wdata >> 5) & 7; m_oe = (wdata >> 8) & 1; end
          1: m_out = (wdata >> 1) & 1;
          2: begin m_en = wdata & 1; m_pol = (wdata >> 1) & 1;
                   m_mode = (wdata >> 2) & 3; m_raw = (wdata >> 4) & 1; end
          4: m_tgt = wdata & 7;
          default: ;
        endcase
      end
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return m_pull | (m_func << 2) | (m_drv << 5) | (m_oe << 8);
      1: return m_s2 | (m_out << 1);
      2: return m_en | (m_pol << 1) | (m_mode << 2) | (m_raw << 4);
      3: return m_st;
      4: return m_tgt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always begin
    @(negedge clk); #2;
    if (rst_n) begin
      chk("R2 pad_oe", pad_oe, m_oe);
      chk("R2 func",   func,   m_func);
      chk("R2 drive",  drive,  m_drv);
      chk("R2 pull",   pull,   m_pull);
      chk("R3 pad_out", pad_out, m_out);
      chk("R9 irq",    irq,    m_st & m_en);
      chk("R11 target", target, m_tgt);
      chk("R6 rdata",  int'(rdata), m_read(int'(addr)));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk); we = 0; #1;
  endtask

  task automatic rd(string req, int a, int exp);
    addr = AW'(a); #1;
    chk(req, int'(rdata), exp);
  endtask

  task automatic setpad(logic v);
    @(negedge clk); pad = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 pad_out", pad_out, 0); chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", irq, 0); chk("R1 target", target, 0);
    rd("R1 cfg", 2, 'h14); rd("R1 status", 3, 0);

    wr(0, 'h1F6);
    chk("R2 func", func, 5); chk("R2 drive", drive, 7);
    chk("R2 pull", pull, 2); chk("R2 oe", pad_oe, 1);
    wr(0, 'h007);
    chk("R2 func", func, 1); chk("R2 drive", drive, 0);
    chk("R2 pull", pull, 3); chk("R2 oe", pad_oe, 0);

    wr(1, 'h3);
    chk("R3 out", pad_out, 1); rd("R3 in low", 1, 'h2);
    setpad(1); idle(3);
    rd("R3 in high", 1, 'h3);
    wr(1, 'h1);
    chk("R3 out", pad_out, 0); rd("R3 in bit ignored", 1, 'h1);

    // level high
    wr(2, 'h13); idle(1);
    chk("R4 level high irq", irq, 1);
    wr(3, 1);
    rd("R5 ack clears", 3, 0); chk("R5 irq", irq, 0);
    idle(1); rd("R5 reasserts", 3, 1);
    setpad(0); idle(3);
    rd("R4 level gone", 3, 0);
    wr(2, 'h11); idle(1);
    rd("R4 level low", 3, 1); chk("R4 irq", irq, 1);

    // edges
    wr(2, 'h15); wr(3, 1);
    rd("R6 cleared", 3, 0);
    wr(2, 'h1B);
    setpad(1); idle(4); rd("R6 fall ignores rise", 3, 0);
    setpad(0); idle(4); rd("R6 fall sets", 3, 1);
    setpad(1); idle(4); rd("R6 sticky", 3, 1);
    wr(3, 1); rd("R6 ack", 3, 0);

    wr(2, 'h1D);
    setpad(0); idle(4); rd("R6 both sets", 3, 1);
    wr(3, 0); rd("R7 wrong sense ignored", 3, 1);
    wr(3, 1); rd("R7 ack", 3, 0);

    // set vs ack race
    setpad(1);
    @(negedge clk);
    @(negedge clk); we = 1; addr = 3; wdata = 1;
    @(negedge clk); we = 0; #1;
    rd("R8 set wins", 3, 1);
    wr(3, 1); rd("R8 later ack", 3, 0);

    // mask
    setpad(0); idle(4); chk("R9 irq on", irq, 1);
    wr(2, 'h1C); chk("R9 masked", irq, 0); rd("R9 status kept", 3, 1);
    wr(2, 'h1D); chk("R9 unmasked", irq, 1);
    wr(3, 1); rd("R9 cleared", 3, 0);

    // raw-detect gating
    wr(2, 'h05);
    setpad(1); idle(4); rd("R10 gated", 3, 0); chk("R10 irq", irq, 0);
    wr(2, 'h15); idle(1); rd("R10 spurious edge", 3, 1);

    wr(4, 5); chk("R11 target", target, 5);
    wr(4, 2); chk("R11 target", target, 2);

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule